// File: doc/BRIEF.md
# PC Card I/O Cycle Sequencer

This block turns a host request into one I/O cycle on a 16-bit PC-card-style I/O port. It first checks whether the host address lies in one of two I/O card windows. Each window can be enabled on its own. For an address in an enabled window, the block drives the card enables and then the I/O read or write strobe, with a programmed setup time, a fixed strobe width and a fixed hold time. Read data comes back on a one-cycle ready pulse.

The card can report that its port is only 8 bits wide, through a width-sense input. The block samples that input on the falling clock edge early in the cycle. If the input is high during a word access in little endian mode, the block drops the upper card enable one and a half cycles later. It then completes the word as two byte transfers on the low data lane. In big endian mode the width-sense input has no effect.

Top module: `pcio_cycle_ctrl`

## Requirements
- R1: `win_hit` is high exactly when `req_addr[31:25]` is 7'h0B with `cfg_win5_card` set (0x16000000 to 0x17FFFFFF), or 7'h0D with `cfg_win6_card` set (0x1A000000 to 0x1BFFFFFF). A request outside both enabled windows starts no cycle: no enable, no strobe and no ready.
- R2: A transfer asserts `card_ce1_n` low for D+S+H cycles. The strobe falls D cycles after the enable, where D = max(1, ceil(cfg_en2stb/2)) and cfg_en2stb is in half cycles. The strobe stays low for S = STB_CYC cycles. The enable is held for H = HOLD_CYC cycles after the strobe rises.
- R3: A read pulses only `card_iord_n` and a write pulses only `card_iowr_n`. The two strobes are never low at the same time.
- R4: A byte access (`req_word`=0) never asserts `card_ce2_n`. It drives write data on bits 7:0 with bits 15:8 zero, and returns read data as {8'h00, card_rdata[7:0]}.
- R5: A word access that is not split asserts both enables for the whole transfer. It moves all 16 bits in a single strobe.
- R6: A word access is split only when all of these hold: `req_le`=1, `cfg_en2stb` >= 3, and `card_iois16` is high at a falling edge during a setup cycle or the first strobe cycle. A high level seen at any later falling edge has no effect.
- R7: `card_ce2_n` rises 1.5 cycles after the first falling edge that sampled `card_iois16` high. If that edge falls in transfer cycle k0, counted from 0 at the first enable cycle, then `card_ce2_n` is low for k0+2 cycles.
- R8: A split access runs two back-to-back transfers, both on data bits 7:0. The first uses the request address and the low byte. The second uses address+1 and the high byte. Read data returns as {second byte, first byte}.
- R9: With `req_le`=0, a word access is never split, whatever `card_iois16` does.
- R10: `rsp_ready` is high for exactly one cycle, N*(D+S+H) cycles after the request is taken, where N is 2 for a split access and 1 otherwise.
- R11: During and after reset, with no request, all card enables and strobes are high, `card_wdata_oe` is low and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; phases move on the rising edge, width sense is sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_addr | input | 32 | Host physical address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| req_le | input | 1 | 1 for little endian mode |
| req_wdata | input | 16 | Write data |
| cfg_win5_card | input | 1 | Enables the 0x16000000 window |
| cfg_win6_card | input | 1 | Enables the 0x1A000000 window |
| cfg_en2stb | input | 4 | Enable-to-strobe delay in half cycles |
| win_hit | output | 1 | Address decodes to an enabled I/O window |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_ready |
| card_addr | output | CARD_AW | Card address |
| card_ce1_n | output | 1 | Lower card enable, active low |
| card_ce2_n | output | 1 | Upper card enable, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_wdata | output | 16 | Write data toward the card |
| card_wdata_oe | output | 1 | Write data drive enable |
| card_rdata | input | 16 | Read data from the card |
| card_iois16 | input | 1 | Card width sense, high means 8-bit port |

## Verification
Every result is tied to a cycle index k, counted from the rising edge that takes the request. The bench drives inputs just after rising edges and reads outputs at falling edges. It computes when each result is due:
- The strobe starts at k = D.
- Data and address are valid in cycle D+S-1 of each transfer.
- The second transfer begins at k = D+S+H.
- The upper enable is active for k0+2 cycles.
- Ready appears at k = N*(D+S+H).

The bench keeps per-access counts of enable, strobe and ready cycles and compares them with these figures. It places width-sense pulses precisely in the first strobe cycle or just after it, so that the edge of the sampling window is tested.

// File: rtl/pcio_pkg.sv
package pcio_pkg;

  localparam int DW = 16;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  localparam logic [6:0] WIN_LO_TAG = 7'h0B;  // 0x16000000..0x17FFFFFF
  localparam logic [6:0] WIN_HI_TAG = 7'h0D;  // 0x1A000000..0x1BFFFFFF

  function automatic logic io_window_hit(input logic [31:0] a,
                                         input logic en_lo,
                                         input logic en_hi);
    return (en_lo && (a[31:25] == WIN_LO_TAG)) ||
           (en_hi && (a[31:25] == WIN_HI_TAG));
  endfunction

  // half-cycle delay rounded up to whole cycles, never below one
  function automatic logic [3:0] setup_cycles(input logic [3:0] half_cyc);
    logic [4:0] c;
    c = ({1'b0, half_cyc} + 5'd1) >> 1;
    if (c == 5'd0) c = 5'd1;
    return c[3:0];
  endfunction

  // width sensing is only honoured for a delay of 1.5 cycles or more
  function automatic logic sizing_allowed(input logic [3:0] half_cyc);
    return half_cyc >= 4'd3;
  endfunction

  function automatic logic [DW-1:0] byte_lane_data(input logic [DW-1:0] wd,
                                                   input logic hi_byte);
    return {8'h00, hi_byte ? wd[15:8] : wd[7:0]};
  endfunction

endpackage

// File: rtl/pcio_win_decode.sv
module pcio_win_decode
  import pcio_pkg::*;
(
  input  logic [31:0] addr,
  input  logic        en_lo,
  input  logic        en_hi,
  output logic        hit
);
  assign hit = io_window_hit(addr, en_lo, en_hi);
endmodule

// File: rtl/pcio_width_sense.sv
module pcio_width_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic window,
  input  logic iois16,
  output logic narrow_q,
  output logic narrow_d
);
  logic samp_n;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) samp_n <= 1'b0;
    else        samp_n <= window & iois16;
  end

  // stage one: half a cycle after the sample; stage two: a full cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      narrow_d <= 1'b0;
    end else if (clr) begin
      narrow_q <= 1'b0;
      narrow_d <= 1'b0;
    end else begin
      narrow_q <= narrow_q | samp_n;
      narrow_d <= narrow_q;
    end
  end

  assert_sample_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $rose(narrow_q)) |-> $past(window));

endmodule

// File: rtl/pcio_phase_seq.sv
module pcio_phase_seq
  import pcio_pkg::*;
#(
  parameter int STB_CYC  = 3,
  parameter int HOLD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] setup_len,
  input  logic       split_req,
  output phase_e     phase,
  output logic       second,
  output logic       strobe_first,
  output logic       strobe_last
);
  localparam int MAXC  = (STB_CYC > HOLD_CYC) ? ((STB_CYC > 8) ? STB_CYC : 8)
                                              : ((HOLD_CYC > 8) ? HOLD_CYC : 8);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] setup_last;
  logic             setup_end, hold_end;

  assign setup_last   = CNT_W'(setup_len - 4'd1);
  assign setup_end    = (phase == PH_SETUP)  && (cnt == setup_last);
  assign strobe_first = (phase == PH_STROBE) && (cnt == '0);
  assign strobe_last  = (phase == PH_STROBE) && (cnt == STB_LAST);
  assign hold_end     = (phase == PH_HOLD)   && (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      second <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SETUP;
          cnt    <= '0;
          second <= 1'b0;
        end
        PH_SETUP: if (setup_end) begin
          phase <= PH_STROBE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_STROBE: if (strobe_last) begin
          phase <= PH_HOLD;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_HOLD: if (hold_end) begin
          cnt <= '0;
          if (!second && split_req) begin
            phase  <= PH_SETUP;
            second <= 1'b1;
          end else begin
            phase <= PH_DONE;
          end
        end else cnt <= cnt + 1'b1;
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_strobe_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> $past(phase) == PH_SETUP);

  assert_second_only_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (second && phase != PH_IDLE) |-> split_req);

endmodule

// File: rtl/pcio_cycle_ctrl.sv
module pcio_cycle_ctrl
  import pcio_pkg::*;
#(
  parameter int STB_CYC  = 3,
  parameter int HOLD_CYC = 2,
  parameter int CARD_AW  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_addr,
  input  logic               req_write,
  input  logic               req_word,
  input  logic               req_le,
  input  logic [15:0]        req_wdata,
  input  logic               cfg_win5_card,
  input  logic               cfg_win6_card,
  input  logic [3:0]         cfg_en2stb,
  output logic               win_hit,
  output logic               rsp_ready,
  output logic [15:0]        rsp_rdata,
  output logic [CARD_AW-1:0] card_addr,
  output logic               card_ce1_n,
  output logic               card_ce2_n,
  output logic               card_iord_n,
  output logic               card_iowr_n,
  output logic [15:0]        card_wdata,
  output logic               card_wdata_oe,
  input  logic [15:0]        card_rdata,
  input  logic               card_iois16
);
  phase_e             phase;
  logic               second, strobe_first, strobe_last;
  logic               start, xfer, strobe, window;
  logic               narrow_q, narrow_d;
  logic               ce1_act, ce2_act, byte_path;
  logic [31:0]        addr_q;
  logic [15:0]        wdata_q, rdata_q;
  logic               wr_q, word_q, le_q;
  logic [3:0]         ted_q, setup_len_q;

  pcio_win_decode u_dec (
    .addr  (req_addr),
    .en_lo (cfg_win5_card),
    .en_hi (cfg_win6_card),
    .hit   (win_hit)
  );

  assign start = req_valid && win_hit && (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      wr_q        <= 1'b0;
      word_q      <= 1'b0;
      le_q        <= 1'b0;
      ted_q       <= '0;
      setup_len_q <= 4'd1;
    end else if (start) begin
      addr_q      <= req_addr;
      wdata_q     <= req_wdata;
      wr_q        <= req_write;
      word_q      <= req_word;
      le_q        <= req_le;
      ted_q       <= cfg_en2stb;
      setup_len_q <= setup_cycles(cfg_en2stb);
    end
  end

  pcio_phase_seq #(.STB_CYC(STB_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .setup_len    (setup_len_q),
    .split_req    (narrow_d),
    .phase        (phase),
    .second       (second),
    .strobe_first (strobe_first),
    .strobe_last  (strobe_last)
  );

  assign xfer   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_STROBE);
  assign window = xfer && !second && word_q && le_q && sizing_allowed(ted_q) &&
                  ((phase == PH_SETUP) || strobe_first);

  pcio_width_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (phase == PH_IDLE),
    .window   (window),
    .iois16   (card_iois16),
    .narrow_q (narrow_q),
    .narrow_d (narrow_d)
  );

  assign ce1_act   = xfer;
  assign ce2_act   = xfer && word_q && !second && !narrow_d;
  assign byte_path = !word_q || narrow_d;

  assign card_ce1_n    = !ce1_act;
  assign card_ce2_n    = !ce2_act;
  assign card_iord_n   = !(strobe && !wr_q);
  assign card_iowr_n   = !(strobe && wr_q);
  assign card_addr     = addr_q[CARD_AW-1:0] + {{(CARD_AW-1){1'b0}}, second};
  assign card_wdata_oe = xfer && wr_q;
  assign card_wdata    = byte_path ? byte_lane_data(wdata_q, second) : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (strobe_last && !wr_q) begin
      if (!word_q)        rdata_q <= {8'h00, card_rdata[7:0]};
      else if (!narrow_d) rdata_q <= card_rdata;
      else if (second)    rdata_q[15:8] <= card_rdata[7:0];
      else                rdata_q[7:0]  <= card_rdata[7:0];
    end
  end

  assign rsp_ready = (phase == PH_DONE);
  assign rsp_rdata = rdata_q;

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_iord_n && !card_iowr_n));

  assert_strobe_in_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_iord_n || !card_iowr_n) |-> !card_ce1_n);

  assert_ce2_with_ce1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !card_ce2_n |-> !card_ce1_n);

  assert_byte_no_ce2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !word_q) |-> card_ce2_n);

  assert_ce2_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && $past(ce2_act) && !ce2_act) |-> $past(narrow_q));

  assert_be_no_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !le_q) |-> !narrow_q);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

endmodule

// File: tb/pcio_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module pcio_cycle_ctrl_tb;
  localparam int S  = 3;
  localparam int H  = 2;
  localparam int AW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_le = 1'b1;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic cfg_win5_card = 1'b0, cfg_win6_card = 1'b0;
  logic [3:0] cfg_en2stb = '0;
  logic iois = 1'b0;
  logic win_hit, rsp_ready, ce1_n, ce2_n, iord_n, iowr_n, wdata_oe;
  logic [15:0] rsp_rdata, card_wdata, card_rdata;
  logic [AW-1:0] card_addr;

  always #2.5 clk = ~clk;

  assign card_rdata = {card_addr[7:0] ^ 8'h5A, card_addr[7:0]};

  pcio_cycle_ctrl #(.STB_CYC(S), .HOLD_CYC(H), .CARD_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_le(req_le),
    .req_wdata(req_wdata), .cfg_win5_card(cfg_win5_card),
    .cfg_win6_card(cfg_win6_card), .cfg_en2stb(cfg_en2stb),
    .win_hit(win_hit), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .card_addr(card_addr), .card_ce1_n(ce1_n), .card_ce2_n(ce2_n),
    .card_iord_n(iord_n), .card_iowr_n(iowr_n), .card_wdata(card_wdata),
    .card_wdata_oe(wdata_oe), .card_rdata(card_rdata), .card_iois16(iois)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        word;
    logic        le;
    logic [3:0]  ted;
    logic        iois;
    logic        a5;
    logic        a6;
    logic [15:0] wd;
    logic        hit;
    logic        split;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h16000010, 1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
    '{32'h16000020, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1},
    '{32'h17FFFF00, 1'b0, 1'b1, 1'b0, 4'd4,  1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
    '{32'h1A000040, 1'b1, 1'b1, 1'b1, 4'd3,  1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b1, 1'b1},
    '{32'h1BFFFFF0, 1'b1, 1'b1, 1'b1, 4'd6,  1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b0},
    '{32'h1A000033, 1'b0, 1'b0, 1'b1, 4'd4,  1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0},
    '{32'h16000005, 1'b1, 1'b0, 1'b0, 4'd1,  1'b0, 1'b1, 1'b0, 16'h77A5, 1'b1, 1'b0},
    '{32'h1A000000, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{32'h18000000, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0},
    '{32'h15FFFFFF, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0},
    '{32'h1C000000, 1'b1, 1'b1, 1'b1, 4'd4,  1'b1, 1'b1, 1'b1, 16'h5555, 1'b0, 1'b0},
    '{32'h1BFFFFFE, 1'b0, 1'b1, 1'b1, 4'd15, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1},
    '{32'h16000000, 1'b1, 1'b1, 1'b1, 4'd2,  1'b1, 1'b1, 1'b0, 16'hCAFE, 1'b1, 1'b0}
  };

  // mode 0: width sense static; 1: high only in first strobe cycle; 2: high from second strobe cycle
  task automatic run_access(input vec_t v, input int mode);
    int d, x, n, len, last_k, k0, exp_ce2;
    int c_ce1, c_ce2, c_rd, c_wr, c_rdy, first_rdy, first_stb;
    logic [AW-1:0] a1, a2, ea;
    logic [15:0] w1, w2, erd;
    d = (v.ted + 1) / 2;
    if (d < 1) d = 1;
    x = d + S + H;
    n = v.split ? 2 : 1;
    len = v.hit ? n * x : 0;
    k0 = (mode == 1) ? d : 0;
    exp_ce2 = (!v.hit || !v.word) ? 0 : (v.split ? k0 + 2 : x);
    last_k = v.hit ? len + 3 : 12;
    c_ce1 = 0; c_ce2 = 0; c_rd = 0; c_wr = 0; c_rdy = 0;
    first_rdy = -1; first_stb = -1;
    a1 = '0; a2 = '0; w1 = '0; w2 = '0;

    @(negedge clk);
    req_addr = v.addr; req_write = v.wr; req_word = v.word; req_le = v.le;
    req_wdata = v.wd; cfg_en2stb = v.ted; cfg_win5_card = v.a5; cfg_win6_card = v.a6;
    iois = (mode == 0) ? v.iois : 1'b0;
    req_valid = 1'b1;
    #1;
    chk("R1 window decode", {31'd0, win_hit}, {31'd0, v.hit});

    for (int k = 0; k <= last_k; k++) begin
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      if (mode == 1) iois = (k == d);
      else if (mode == 2) iois = (k >= d + 1) && (k < x);
      @(negedge clk);
      if (!ce1_n) c_ce1++;
      if (!ce2_n) c_ce2++;
      if (!iord_n) c_rd++;
      if (!iowr_n) c_wr++;
      if (first_stb < 0 && (!iord_n || !iowr_n)) first_stb = k;
      if (rsp_ready) begin
        c_rdy++;
        if (first_rdy < 0) first_rdy = k;
      end
      if (k == d + S - 1)     begin a1 = card_addr; w1 = card_wdata; end
      if (k == x + d + S - 1) begin a2 = card_addr; w2 = card_wdata; end
    end
    iois = 1'b0;

    chk("R10 ready count", c_rdy, v.hit ? 1 : 0);
    chk("R2 enable cycles", c_ce1, len);
    if (!v.hit) begin
      chk("R1 no strobe on miss", c_rd + c_wr, 0);
      return;
    end
    chk("R10 ready latency", first_rdy, len);
    chk("R2 strobe start", first_stb, d);
    chk("R3 read strobe cycles", c_rd, v.wr ? 0 : n * S);
    chk("R3 write strobe cycles", c_wr, v.wr ? n * S : 0);
    chk("R7 upper enable cycles (R4 R5)", c_ce2, exp_ce2);
    ea = v.addr[AW-1:0];
    chk("R8 first address", a1, ea);
    if (v.split) chk("R8 second address", a2, ea + 1'b1);
    if (v.wr) begin
      if (v.split) begin
        chk("R8 low byte lane", w1, {8'h00, v.wd[7:0]});
        chk("R8 high byte lane", w2, {8'h00, v.wd[15:8]});
      end else if (!v.word) begin
        chk("R4 byte write lane", w1, {8'h00, v.wd[7:0]});
      end else begin
        chk("R5 word write data", w1, v.wd);
      end
    end else begin
      if (v.split)      erd = {ea[7:0] + 8'h01, ea[7:0]};
      else if (!v.word) erd = {8'h00, ea[7:0]};
      else              erd = {ea[7:0] ^ 8'h5A, ea[7:0]};
      chk(v.split ? "R8 split read data" : (v.word ? "R5 word read data" : "R4 byte read data"),
          rsp_rdata, erd);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t dv;
    repeat (3) @(negedge clk);
    chk("R11 reset ce1", ce1_n, 1'b1);
    chk("R11 reset strobes", {iord_n, iowr_n}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 idle enables", {ce1_n, ce2_n}, 2'b11);
    chk("R11 idle ready/oe", {rsp_ready, wdata_oe}, 2'b00);

    for (int i = 0; i < NV; i++) run_access(VECS[i], 0);

    // R6: width sense only in the first strobe cycle still splits, R7 lag from there
    dv = '{32'h16000100, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b1};
    run_access(dv, 1);
    // R6: width sense rising after the window is ignored
    dv = '{32'h16000200, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0};
    run_access(dv, 2);
    // R9: big endian ignores a first-strobe pulse as well
    dv = '{32'h1A000300, 1'b0, 1'b1, 1'b0, 4'd4, 1'b1, 1'b0, 1'b1, 16'h0, 1'b1, 1'b0};
    run_access(dv, 1);

    @(negedge clk);
    chk("R11 idle after traffic", {ce1_n, ce2_n, iord_n, iowr_n}, 4'hF);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule